// File: doc/BRIEF.md
# Call-Depth Windowed Register File

This block is the 16-entry architectural register file of a small controller core. The core gets cheap procedure calls by keeping a separate physical bank for every hardware call level. A depth pointer selects the active level. The call and return strobes move that pointer. The register number picks one of four classes, and each class behaves differently:

- **Private registers, r0 to r6.** Each level has its own copy.
- **Shared registers, r7 to r9.** All levels use one copy.
- **Parameter registers, r10 to r13.** Writes fill the current level's outgoing slots. Reads return the slots that the caller filled.
- **Result registers, r14 and r15.** Writes go to a slot that only the caller can read. Reads return what the deeper level left there before it returned.

There are two combinational read ports and one write port, which updates on the clock edge. When a call would go above the top hardware level, or a return would go below level 0, the block leaves the pointer and every bank unchanged. It raises a one-cycle pulse so that an outside spill or fill engine can act. If a call and a return arrive together, the block treats them as a conflict and raises its own pulse.

The depth controller is a state machine with three states:
- `LV_FLOOR`: depth 0.
- `LV_MID`: strictly between 0 and the top level.
- `LV_CEIL`: the top level, LEVELS-1.

Its transitions are:
- `CALL_UP`: a call that is not at the ceiling. Depth goes up by one. The next state comes from the new depth.
- `RET_DOWN`: a return that is not at the floor. Depth goes down by one.
- `CALL_OVER`: a call in `LV_CEIL`. Raises an overflow pulse and keeps the state.
- `RET_UNDER`: a return in `LV_FLOOR`. Raises an underflow pulse and keeps the state.
- `STROBE_CLASH`: call and return together. Raises a clash pulse and keeps the state.

Top module: `wrf_regfile`

## Requirements
- R1: After reset, depth_o is 0, the three pulse outputs are low, and every register reads 0 at every level.
- R2: A write to r0..r6 at depth D changes only what depth D reads from that register. Values written at other depths are still there after calls and returns.
- R3: r7..r9 have one copy. A value written at any depth is read back at every depth from the cycle after the write, on either read port.
- R4: A write to r10..r13 at depth D does not change what depth D reads from r10..r13. A read of r10..r13 at depth D>0 returns what depth D-1 last wrote there. At depth 0 such a read returns 0.
- R5: A write to r14..r15 at depth D does not change what depth D reads from r14..r15. A read at depth D returns what depth D+1 last wrote there. At depth LEVELS-1 such a read returns 0.
- R6: A call alone below the top level raises depth_o by one at the next edge. A return alone above level 0 lowers it by one.
- R7: A call alone at depth LEVELS-1 sets ovf_o for exactly the following cycle and leaves depth_o and all stored values unchanged.
- R8: A return alone at depth 0 sets unf_o for exactly the following cycle and leaves depth_o at 0.
- R9: A call and a return in the same cycle set clash_o for the following cycle and leave depth_o unchanged. At most one of ovf_o, unf_o and clash_o is high in any cycle.
- R10: A write in the same cycle as a call or return is stored at the old depth. Reads in that cycle use the old depth.
- R11: A read of the register being written in the same cycle returns the value stored before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| call_i | input | 1 | Call strobe: enter the next level |
| ret_i | input | 1 | Return strobe: go back to the previous level |
| we_i | input | 1 | Write enable |
| waddr_i | input | 4 | Register number to write |
| wdata_i | input | DW | Write data |
| ra_addr_i | input | 4 | Register number for read port A |
| ra_data_o | output | DW | Read port A data, combinational |
| rb_addr_i | input | 4 | Register number for read port B |
| rb_data_o | output | DW | Read port B data, combinational |
| depth_o | output | $clog2(LEVELS) | Current call level |
| ovf_o | output | 1 | One-cycle pulse: a call found no free level |
| unf_o | output | 1 | One-cycle pulse: a return found no stored level |
| clash_o | output | 1 | One-cycle pulse: call and return arrived together |

## Verification
Read data is due in the same cycle as the address and depth that select it. The bench therefore samples it 1 ns after driving the inputs, before the next edge. That sample also shows that a write in the same cycle is not yet visible. Depth and the three pulses are registered once, so they are due one edge after the strobe. The bench samples them 1 ns after that edge, and it also checks that a pulse has dropped by the cycle after. Stored values are due one edge after the write. The bench reads them back only in a later vector, and often after further calls and returns, so that it sees which bank each write went to.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

    typedef enum logic [1:0] {
        LV_FLOOR,
        LV_MID,
        LV_CEIL
    } lvl_state_t;

    typedef enum logic [1:0] {
        RG_PRIV,
        RG_SHARED,
        RG_PARAM,
        RG_RESULT
    } reg_class_t;

    localparam int unsigned NUM_PRIV   = 7;
    localparam int unsigned NUM_SHARED = 3;
    localparam int unsigned NUM_PARAM  = 4;
    localparam int unsigned NUM_RESULT = 2;

    function automatic reg_class_t classify(input logic [3:0] rn);
        if (rn <= 4'd6)       return RG_PRIV;
        else if (rn <= 4'd9)  return RG_SHARED;
        else if (rn <= 4'd13) return RG_PARAM;
        else                  return RG_RESULT;
    endfunction

    // r7,r8,r9 -> slot 0,1,2 (low bits 11,00,01 plus one)
    function automatic logic [1:0] shared_slot(input logic [1:0] lo);
        return lo + 2'd1;
    endfunction

    // r10..r13 -> slot 0..3 (low bits 10,11,00,01 plus two)
    function automatic logic [1:0] param_slot(input logic [1:0] lo);
        return lo + 2'd2;
    endfunction

endpackage

// File: rtl/wrf_depth_ctrl.sv
module wrf_depth_ctrl
    import wrf_pkg::*;
#(
    parameter int unsigned LEVELS = 4,
    parameter int unsigned DPW    = $clog2(LEVELS)
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           call_i,
    input  logic           ret_i,
    output logic [DPW-1:0] depth_o,
    output logic           ovf_o,
    output logic           unf_o,
    output logic           clash_o
);

    localparam logic [DPW-1:0] TOP = DPW'(LEVELS - 1);

    lvl_state_t     state_q, state_n;
    logic [DPW-1:0] depth_q, depth_n;
    logic           ovf_n, unf_n, clash_n;
    logic           step_up, step_dn;

    assign step_up = call_i & ~ret_i;
    assign step_dn = ret_i & ~call_i;

    always_comb begin
        depth_n = depth_q;
        ovf_n   = 1'b0;
        unf_n   = 1'b0;
        clash_n = call_i & ret_i;            // STROBE_CLASH
        unique case (state_q)
            LV_FLOOR: begin
                if (step_up)      depth_n = depth_q + DPW'(1);   // CALL_UP
                else if (step_dn) unf_n   = 1'b1;                // RET_UNDER
            end
            LV_MID: begin
                if (step_up)      depth_n = depth_q + DPW'(1);   // CALL_UP
                else if (step_dn) depth_n = depth_q - DPW'(1);   // RET_DOWN
            end
            LV_CEIL: begin
                if (step_up)      ovf_n   = 1'b1;                // CALL_OVER
                else if (step_dn) depth_n = depth_q - DPW'(1);   // RET_DOWN
            end
            default: depth_n = '0;
        endcase

        if (depth_n == '0)      state_n = LV_FLOOR;
        else if (depth_n == TOP) state_n = LV_CEIL;
        else                     state_n = LV_MID;
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= LV_FLOOR;
            depth_q <= '0;
        end else begin
            state_q <= state_n;
            depth_q <= depth_n;
        end
    end

    // output pulses
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ovf_o   <= 1'b0;
            unf_o   <= 1'b0;
            clash_o <= 1'b0;
        end else begin
            ovf_o   <= ovf_n;
            unf_o   <= unf_n;
            clash_o <= clash_n;
        end
    end

    assign depth_o = depth_q;

endmodule

// File: rtl/wrf_bank_store.sv
module wrf_bank_store
    import wrf_pkg::*;
#(
    parameter int unsigned DW     = 16,
    parameter int unsigned LEVELS = 4,
    parameter int unsigned DPW    = $clog2(LEVELS)
) (
    input  logic                                        clk_i,
    input  logic                                        rst_ni,
    input  logic                                        we_i,
    input  logic [3:0]                                  waddr_i,
    input  logic [DW-1:0]                               wdata_i,
    input  logic [DPW-1:0]                              depth_i,
    output logic [LEVELS-1:0][NUM_PRIV-1:0][DW-1:0]     priv_o,
    output logic [NUM_SHARED-1:0][DW-1:0]               shared_o,
    output logic [LEVELS-1:0][NUM_PARAM-1:0][DW-1:0]    param_o,
    output logic [LEVELS-1:0][NUM_RESULT-1:0][DW-1:0]   result_o
);

    reg_class_t wclass;
    assign wclass = classify(waddr_i);

    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
        logic [NUM_PRIV-1:0][DW-1:0]   priv_q;
        logic [NUM_PARAM-1:0][DW-1:0]  param_q;
        logic [NUM_RESULT-1:0][DW-1:0] result_q;
        logic                          sel;

        assign sel = we_i && (depth_i == DPW'(lv));

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                priv_q   <= '0;
                param_q  <= '0;
                result_q <= '0;
            end else if (sel) begin
                unique case (wclass)
                    RG_PRIV:   priv_q[waddr_i[2:0]]              <= wdata_i;
                    RG_PARAM:  param_q[param_slot(waddr_i[1:0])] <= wdata_i;
                    RG_RESULT: result_q[waddr_i[0]]              <= wdata_i;
                    default: ;
                endcase
            end
        end

        assign priv_o[lv]   = priv_q;
        assign param_o[lv]  = param_q;
        assign result_o[lv] = result_q;
    end

    logic [NUM_SHARED-1:0][DW-1:0] shared_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            shared_q <= '0;
        end else if (we_i && wclass == RG_SHARED) begin
            shared_q[shared_slot(waddr_i[1:0])] <= wdata_i;
        end
    end

    assign shared_o = shared_q;

endmodule

// File: rtl/wrf_read_port.sv
module wrf_read_port
    import wrf_pkg::*;
#(
    parameter int unsigned DW     = 16,
    parameter int unsigned LEVELS = 4,
    parameter int unsigned DPW    = $clog2(LEVELS)
) (
    input  logic [3:0]                                  raddr_i,
    input  logic [DPW-1:0]                              depth_i,
    input  logic [LEVELS-1:0][NUM_PRIV-1:0][DW-1:0]     priv_i,
    input  logic [NUM_SHARED-1:0][DW-1:0]               shared_i,
    input  logic [LEVELS-1:0][NUM_PARAM-1:0][DW-1:0]    param_i,
    input  logic [LEVELS-1:0][NUM_RESULT-1:0][DW-1:0]   result_i,
    output logic [DW-1:0]                               rdata_o
);

    localparam logic [DPW-1:0] TOP = DPW'(LEVELS - 1);

    logic [DPW-1:0] caller_lv, callee_lv;
    assign caller_lv = depth_i - DPW'(1);
    assign callee_lv = depth_i + DPW'(1);

    always_comb begin
        rdata_o = '0;
        unique case (classify(raddr_i))
            RG_PRIV:   rdata_o = priv_i[depth_i][raddr_i[2:0]];
            RG_SHARED: rdata_o = shared_i[shared_slot(raddr_i[1:0])];
            RG_PARAM:  if (depth_i != '0)
                           rdata_o = param_i[caller_lv][param_slot(raddr_i[1:0])];
            RG_RESULT: if (depth_i != TOP)
                           rdata_o = result_i[callee_lv][raddr_i[0]];
            default: ;
        endcase
    end

endmodule

// File: rtl/wrf_regfile.sv
module wrf_regfile
    import wrf_pkg::*;
#(
    parameter  int unsigned DW     = 16,
    parameter  int unsigned LEVELS = 4,
    localparam int unsigned DPW    = $clog2(LEVELS)
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           call_i,
    input  logic           ret_i,
    input  logic           we_i,
    input  logic [3:0]     waddr_i,
    input  logic [DW-1:0]  wdata_i,
    input  logic [3:0]     ra_addr_i,
    output logic [DW-1:0]  ra_data_o,
    input  logic [3:0]     rb_addr_i,
    output logic [DW-1:0]  rb_data_o,
    output logic [DPW-1:0] depth_o,
    output logic           ovf_o,
    output logic           unf_o,
    output logic           clash_o
);

    localparam int unsigned NRD = 2;

    logic [DPW-1:0]                              depth;
    logic [LEVELS-1:0][NUM_PRIV-1:0][DW-1:0]     priv;
    logic [NUM_SHARED-1:0][DW-1:0]               shared;
    logic [LEVELS-1:0][NUM_PARAM-1:0][DW-1:0]    param;
    logic [LEVELS-1:0][NUM_RESULT-1:0][DW-1:0]   result;

    wrf_depth_ctrl #(.LEVELS(LEVELS), .DPW(DPW)) u_ctrl (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .call_i  (call_i),
        .ret_i   (ret_i),
        .depth_o (depth),
        .ovf_o   (ovf_o),
        .unf_o   (unf_o),
        .clash_o (clash_o)
    );

    wrf_bank_store #(.DW(DW), .LEVELS(LEVELS), .DPW(DPW)) u_store (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .we_i     (we_i),
        .waddr_i  (waddr_i),
        .wdata_i  (wdata_i),
        .depth_i  (depth),
        .priv_o   (priv),
        .shared_o (shared),
        .param_o  (param),
        .result_o (result)
    );

    logic [NRD-1:0][3:0]    rd_addr;
    logic [NRD-1:0][DW-1:0] rd_data;

    assign rd_addr[0] = ra_addr_i;
    assign rd_addr[1] = rb_addr_i;

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        wrf_read_port #(.DW(DW), .LEVELS(LEVELS), .DPW(DPW)) u_port (
            .raddr_i  (rd_addr[p]),
            .depth_i  (depth),
            .priv_i   (priv),
            .shared_i (shared),
            .param_i  (param),
            .result_i (result),
            .rdata_o  (rd_data[p])
        );
    end

    assign ra_data_o = rd_data[0];
    assign rb_data_o = rd_data[1];
    assign depth_o   = depth;

endmodule

// File: rtl/wrf_regfile_chk.sv
module wrf_regfile_chk #(
    parameter int unsigned DW     = 16,
    parameter int unsigned LEVELS = 4,
    parameter int unsigned DPW    = $clog2(LEVELS)
) (
    input logic           clk_i,
    input logic           rst_ni,
    input logic           call_i,
    input logic           ret_i,
    input logic           we_i,
    input logic [3:0]     waddr_i,
    input logic [DW-1:0]  wdata_i,
    input logic [3:0]     ra_addr_i,
    input logic [DW-1:0]  ra_data_o,
    input logic [3:0]     rb_addr_i,
    input logic [DW-1:0]  rb_data_o,
    input logic [DPW-1:0] depth_o,
    input logic           ovf_o,
    input logic           unf_o,
    input logic           clash_o
);

    localparam logic [DPW-1:0] TOP = DPW'(LEVELS - 1);

    assert_call_up_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (call_i && !ret_i && depth_o != TOP) |=> depth_o == $past(depth_o) + DPW'(1));

    assert_ret_down_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ret_i && !call_i && depth_o != '0) |=> depth_o == $past(depth_o) - DPW'(1));

    assert_overflow_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (call_i && !ret_i && depth_o == TOP) |=> (ovf_o && $stable(depth_o)));

    assert_underflow_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ret_i && !call_i && depth_o == '0) |=> (unf_o && depth_o == '0));

    assert_clash_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (call_i && ret_i) |=> (clash_o && $stable(depth_o)));

    assert_single_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({ovf_o, unf_o, clash_o}));

    assert_shared_a_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && waddr_i == 4'd8) ##1 (ra_addr_i == 4'd8) |-> ra_data_o == $past(wdata_i));

    assert_shared_b_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && waddr_i == 4'd9) ##1 (rb_addr_i == 4'd9) |-> rb_data_o == $past(wdata_i));

    assert_param_blind_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && waddr_i >= 4'd10 && waddr_i <= 4'd13 && !call_i && !ret_i
            && ra_addr_i == waddr_i)
        ##1 (ra_addr_i == $past(ra_addr_i)) |-> ra_data_o == $past(ra_data_o));

    assert_result_blind_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && waddr_i >= 4'd14 && !call_i && !ret_i && ra_addr_i == waddr_i)
        ##1 (ra_addr_i == $past(ra_addr_i)) |-> ra_data_o == $past(ra_data_o));

endmodule

bind wrf_regfile wrf_regfile_chk #(.DW(DW), .LEVELS(LEVELS), .DPW(DPW)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .call_i    (call_i),
    .ret_i     (ret_i),
    .we_i      (we_i),
    .waddr_i   (waddr_i),
    .wdata_i   (wdata_i),
    .ra_addr_i (ra_addr_i),
    .ra_data_o (ra_data_o),
    .rb_addr_i (rb_addr_i),
    .rb_data_o (rb_data_o),
    .depth_o   (depth_o),
    .ovf_o     (ovf_o),
    .unf_o     (unf_o),
    .clash_o   (clash_o)
);

// File: tb/wrf_regfile_test.sv
module wrf_regfile_test;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int LEVELS = 4;
    localparam int NVEC = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          call = 1'b0, ret = 1'b0, we = 1'b0;
    logic [3:0]    waddr = '0, ra = '0, rb = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] ra_data, rb_data;
    logic [1:0]    depth;
    logic          ovf, unf, clash;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wrf_regfile #(.DW(DW), .LEVELS(LEVELS)) uut (
        .clk_i(clk), .rst_ni(rst_n), .call_i(call), .ret_i(ret),
        .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
        .ra_addr_i(ra), .ra_data_o(ra_data),
        .rb_addr_i(rb), .rb_data_o(rb_data),
        .depth_o(depth), .ovf_o(ovf), .unf_o(unf), .clash_o(clash)
    );

    // {req, call, ret, we, waddr, wdata, ra, exp_rd (pre-edge), exp_depth, exp {ovf,unf,clash}}
    localparam logic [51:0] VEC [NVEC] = '{
        {4'd11, 1'b0,1'b0,1'b1, 4'd1,  16'h1111, 4'd1,  16'h0000, 2'd0, 3'b000},
        {4'd2,  1'b0,1'b0,1'b1, 4'd7,  16'h7777, 4'd1,  16'h1111, 2'd0, 3'b000},
        {4'd4,  1'b0,1'b0,1'b1, 4'd10, 16'hA0A0, 4'd10, 16'h0000, 2'd0, 3'b000},
        {4'd10, 1'b1,1'b0,1'b1, 4'd11, 16'hB1B1, 4'd7,  16'h7777, 2'd1, 3'b000},
        {4'd2,  1'b0,1'b0,1'b1, 4'd1,  16'h2222, 4'd1,  16'h0000, 2'd1, 3'b000},
        {4'd4,  1'b0,1'b0,1'b0, 4'd0,  16'h0000, 4'd10, 16'hA0A0, 2'd1, 3'b000},
        {4'd10, 1'b0,1'b0,1'b0, 4'd0,  16'h0000, 4'd11, 16'hB1B1, 2'd1, 3'b000},
        {4'd2,  1'b0,1'b0,1'b1, 4'd10, 16'hC0C0, 4'd1,  16'h2222, 2'd1, 3'b000},
        {4'd4,  1'b0,1'b0,1'b0, 4'd0,  16'h0000, 4'd10, 16'hA0A0, 2'd1, 3'b000},
        {4'd3,  1'b0,1'b0,1'b1, 4'd14, 16'hE4E4, 4'd7,  16'h7777, 2'd1, 3'b000},
        {4'd5,  1'b0,1'b1,1'b0, 4'd0,  16'h0000, 4'd14, 16'h0000, 2'd0, 3'b000},
        {4'd5,  1'b0,1'b0,1'b0, 4'd0,  16'h0000, 4'd14, 16'hE4E4, 2'd0, 3'b000},
        {4'd2,  1'b0,1'b0,1'b0, 4'd0,  16'h0000, 4'd1,  16'h1111, 2'd0, 3'b000},
        {4'd5,  1'b1,1'b0,1'b0, 4'd0,  16'h0000, 4'd15, 16'h0000, 2'd1, 3'b000},
        {4'd2,  1'b0,1'b0,1'b0, 4'd0,  16'h0000, 4'd1,  16'h2222, 2'd1, 3'b000},
        {4'd10, 1'b1,1'b0,1'b0, 4'd0,  16'h0000, 4'd10, 16'hA0A0, 2'd2, 3'b000},
        {4'd4,  1'b0,1'b0,1'b0, 4'd0,  16'h0000, 4'd10, 16'hC0C0, 2'd2, 3'b000},
        {4'd2,  1'b0,1'b0,1'b1, 4'd7,  16'h7A7A, 4'd1,  16'h0000, 2'd2, 3'b000},
        {4'd9,  1'b1,1'b1,1'b0, 4'd0,  16'h0000, 4'd7,  16'h7A7A, 2'd2, 3'b001},
        {4'd3,  1'b1,1'b0,1'b0, 4'd0,  16'h0000, 4'd7,  16'h7A7A, 2'd3, 3'b000},
        {4'd5,  1'b0,1'b0,1'b1, 4'd15, 16'hF5F5, 4'd14, 16'h0000, 2'd3, 3'b000},
        {4'd7,  1'b1,1'b0,1'b0, 4'd0,  16'h0000, 4'd15, 16'h0000, 2'd3, 3'b100},
        {4'd6,  1'b0,1'b1,1'b0, 4'd0,  16'h0000, 4'd1,  16'h0000, 2'd2, 3'b000},
        {4'd7,  1'b0,1'b0,1'b0, 4'd0,  16'h0000, 4'd15, 16'hF5F5, 2'd2, 3'b000}
    };

    function automatic string tag_of(input logic [3:0] r);
        case (r)
            4'd2:  return "R2";
            4'd3:  return "R3";
            4'd4:  return "R4";
            4'd5:  return "R5";
            4'd6:  return "R6";
            4'd7:  return "R7";
            4'd9:  return "R9";
            4'd10: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        call = 1'b0; ret = 1'b0; we = 1'b0;
    endtask

    task automatic run_vec(input logic [51:0] v);
        string t;
        t = tag_of(v[51:48]);
        call = v[47]; ret = v[46]; we = v[45];
        waddr = v[44:41]; wdata = v[40:25]; ra = v[24:21];
        #1;
        check(t, "read data", 32'(ra_data), 32'(v[20:5]));
        @(posedge clk);
        #1;
        check("R6", "depth", 32'(depth), 32'(v[4:3]));
        check(t, "pulses", 32'({ovf, unf, clash}), 32'(v[2:0]));
        @(negedge clk);
        idle();
    endtask

    initial begin
        // R1: reset state
        ra = 4'd1; rb = 4'd14;
        repeat (2) @(posedge clk);
        #1;
        check("R1", "depth at reset", 32'(depth), 32'd0);
        check("R1", "pulses at reset", 32'({ovf, unf, clash}), 32'd0);
        check("R1", "port A at reset", 32'(ra_data), 32'd0);
        check("R1", "port B at reset", 32'(rb_data), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) run_vec(VEC[i]);

        // R3: port B sees the shared value written at another depth
        rb = 4'd7;
        #1;
        check("R3", "port B shared", 32'(rb_data), 32'h7A7A);

        // R8: unwind to depth 0, then one return too many
        ret = 1'b1;
        @(posedge clk); #1;
        check("R6", "depth after return", 32'(depth), 32'd1);
        @(posedge clk); #1;
        check("R6", "depth at floor", 32'(depth), 32'd0);
        check("R8", "no pulse yet", 32'(unf), 32'd0);
        @(posedge clk); #1;
        check("R8", "underflow pulse", 32'(unf), 32'd1);
        check("R8", "depth held at 0", 32'(depth), 32'd0);
        @(negedge clk);
        idle();
        @(posedge clk); #1;
        check("R8", "pulse is one cycle", 32'(unf), 32'd0);
        ra = 4'd14;
        #1;
        check("R5", "result from depth 1 after unwind", 32'(ra_data), 32'hE4E4);

        // R7: overflow left the pulse for exactly one cycle and then cleared
        @(negedge clk);
        call = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R6", "depth at ceiling", 32'(depth), 32'd3);
        @(posedge clk); #1;
        check("R7", "overflow pulse", 32'(ovf), 32'd1);
        @(negedge clk);
        idle();
        @(posedge clk); #1;
        check("R7", "overflow pulse clears", 32'(ovf), 32'd0);
        check("R7", "depth kept", 32'(depth), 32'd3);

        // R1: reset mid-run clears the banks
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        ra = 4'd7; rb = 4'd1;
        #1;
        check("R1", "depth after reset", 32'(depth), 32'd0);
        check("R1", "shared cleared", 32'(ra_data), 32'd0);
        check("R1", "private cleared", 32'(rb_data), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule